// File: doc/BRIEF.md
# Detection Job Control Sequencer

This block is the job controller that sits in front of a hardware detection engine. Software writes a small control word to start a job, hold the engine in its own reset, or acknowledge a finished job. It also programs the detection condition, the search window, the match threshold and two aligned memory base addresses. The block gives the engine a one-cycle start pulse and tracks whether a job is in flight. When the engine reports completion it latches the completion flag and the result count, and it raises a one-cycle processing-done event toward the interrupt controller. A bus error reported by the engine is forwarded as its own one-cycle event.

The control word has a different meaning on read than on write. On write, a 1 in a bit is a command: start, clear completion, or enter engine reset. On read, the same bits show status: engine in reset, job running, job complete. Writes that would put the block in an undefined state are filtered out, and out-of-range window and threshold values are clamped, so the engine never sees a setting it cannot handle.

Top module: `det_job_seq`

## Requirements
- R1: Register word addresses are 0 control, 1 result count, 2 condition, 3 window X start, 4 window Y start, 5 window width, 6 window height, 7 threshold, 8 picture base, 9 work base. Reading control returns bit 0 = engine reset held, bit 1 = job running, bit 2 = job complete, and zeros above.
- R2: A control write with bit 1 set, while idle and outside engine reset, produces exactly one cycle of `eng_start` in the cycle after the write edge, and the running bit reads 1 from then on.
- R3: A start command issued while a job is running, while engine reset is held, or together with bit 0 in the same write, produces no start pulse and leaves the status unchanged.
- R4: An engine done pulse during a job clears running, sets complete and gives one cycle of `evt_done` in the following cycle; a done pulse with no job running changes nothing and gives no event.
- R5: On an accepted done pulse the result count is captured from `eng_count`, saturating at 35, and read back at address 1.
- R6: A control write with bit 2 set clears the complete flag; writing 0 to bit 2 leaves it as it is.
- R7: Control bit 0 is a level: writing 1 drives `eng_sreset` high and reads back 1, writing 0 releases it; entering engine reset aborts a running job without a done event.
- R8: A control write with bits 0, 1 and 2 all set is discarded entirely.
- R9: Writes to X start, Y start and threshold are clamped to 160, 120 and 9 respectively; width and height are stored as written.
- R10: Condition bits [3:2] hold the direction (0 up, 1 right, 2 left); a write carrying the reserved code 3 keeps the previous direction. Bits [1:0] hold the minimum size code, output as 20, 25, 32 or 40 pixels on `cond_min_px`.
- R11: The picture and work base registers read and drive their 5 least significant bits as zero.
- R12: A cycle of `eng_bus_err` gives one cycle of `evt_err` in the following cycle.
- R13: After reset every register and output is zero, except `cond_min_px` which shows 20.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | 4 | Register read word address |
| rd_data | output | DW | Register read data (combinational) |
| eng_done | input | 1 | Engine job-complete pulse |
| eng_count | input | CNT_W | Engine result count, valid with eng_done |
| eng_bus_err | input | 1 | Engine bus error pulse |
| eng_start | output | 1 | One-cycle job start pulse |
| eng_sreset | output | 1 | Engine-only reset level |
| evt_done | output | 1 | One-cycle processing-done event |
| evt_err | output | 1 | One-cycle bus-error event |
| cond_dir | output | 2 | Detection direction code |
| cond_min_px | output | 6 | Minimum face size in pixels |
| area_x0 | output | X_W | Window X start |
| area_y0 | output | Y_W | Window Y start |
| area_w | output | W_W | Window width |
| area_h | output | H_W | Window height |
| hit_thr | output | T_W | Match threshold |
| pic_base | output | DW | Picture base address, 32-byte aligned |
| work_base | output | DW | Work area base address, 32-byte aligned |

## Verification
The bench builds the block with its default parameters: a 6-bit count with a cap of 35, and window limits of 160 and 120 inside 8- and 7-bit fields. With these values a raw engine count of 50 exercises saturation, and written values of 200, 127 and 15 land above the limits while still fitting the fields. Full-word base writes show the alignment mask. Start, done and error pulses are predicted cycle by cycle and matched in order, so a missing, late or extra pulse is caught.

// File: rtl/djs_pkg.sv
package djs_pkg;

  typedef enum logic [3:0] {
    RA_CTRL   = 4'd0,
    RA_COUNT  = 4'd1,
    RA_COND   = 4'd2,
    RA_X0     = 4'd3,
    RA_Y0     = 4'd4,
    RA_WIDTH  = 4'd5,
    RA_HEIGHT = 4'd6,
    RA_THR    = 4'd7,
    RA_PIC    = 4'd8,
    RA_WORK   = 4'd9
  } reg_addr_e;

  typedef enum logic [1:0] {
    DIR_UP    = 2'd0,
    DIR_RIGHT = 2'd1,
    DIR_LEFT  = 2'd2,
    DIR_RSVD  = 2'd3
  } dir_e;

  // Control word bit positions (write: command, read: status)
  localparam int CB_SRST = 0;
  localparam int CB_RUN  = 1;
  localparam int CB_FIN  = 2;

  // Upper-bound a value; used for window clamps and count saturation
  function automatic logic [31:0] clamp_max(input logic [31:0] v, input logic [31:0] lim);
    return (v > lim) ? lim : v;
  endfunction

  // Minimum size code to pixel count
  function automatic logic [5:0] min_code_px(input logic [1:0] code);
    case (code)
      2'd0:    return 6'd20;
      2'd1:    return 6'd25;
      2'd2:    return 6'd32;
      default: return 6'd40;
    endcase
  endfunction

endpackage

// File: rtl/djs_ctrl.sv
module djs_ctrl
  import djs_pkg::*;
#(
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 35
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic [2:0]       ctrl_wdata,
  input  logic             eng_done,
  input  logic [CNT_W-1:0] eng_count,
  output logic             busy,
  output logic             fin,
  output logic             sreset,
  output logic             start_pulse,
  output logic             done_evt,
  output logic [CNT_W-1:0] count,
  output logic             ctrl_acc,
  output logic             start_ok,
  output logic             done_ok
);

  logic enter_rst;

  // A word with every command bit set is undefined and dropped
  assign ctrl_acc  = ctrl_we && !(&ctrl_wdata);
  assign enter_rst = ctrl_acc && ctrl_wdata[CB_SRST];
  assign start_ok  = ctrl_acc && ctrl_wdata[CB_RUN] && !ctrl_wdata[CB_SRST]
                     && !busy && !sreset;
  assign done_ok   = eng_done && busy && !enter_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy        <= 1'b0;
      fin         <= 1'b0;
      sreset      <= 1'b0;
      start_pulse <= 1'b0;
      done_evt    <= 1'b0;
      count       <= '0;
    end else begin
      start_pulse <= start_ok;
      done_evt    <= done_ok;
      if (ctrl_acc) sreset <= ctrl_wdata[CB_SRST];
      if (enter_rst)     busy <= 1'b0;
      else if (start_ok) busy <= 1'b1;
      else if (done_ok)  busy <= 1'b0;
      if (done_ok)                           fin <= 1'b1;
      else if (ctrl_acc && ctrl_wdata[CB_FIN]) fin <= 1'b0;
      if (done_ok) count <= CNT_W'(clamp_max(32'(eng_count), 32'(CNT_MAX)));
    end
  end

endmodule

// File: rtl/djs_params.sv
module djs_params
  import djs_pkg::*;
#(
  parameter int DW    = 32,
  parameter int X_W   = 8,
  parameter int Y_W   = 7,
  parameter int W_W   = 9,
  parameter int H_W   = 8,
  parameter int T_W   = 4,
  parameter int X_MAX = 160,
  parameter int Y_MAX = 120,
  parameter int T_MAX = 9,
  parameter int ALIGN = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [3:0]     waddr,
  input  logic [DW-1:0]  wdata,
  output logic [1:0]     dir,
  output logic [1:0]     min_code,
  output logic [X_W-1:0] x0,
  output logic [Y_W-1:0] y0,
  output logic [W_W-1:0] w,
  output logic [H_W-1:0] h,
  output logic [T_W-1:0] thr,
  output logic [DW-1:0]  pic_base,
  output logic [DW-1:0]  work_base
);

  localparam int NBASE = 2;

  logic [31:0]   wd32;
  logic [DW-1:0] base_q [NBASE];

  assign wd32 = 32'(wdata);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir      <= DIR_UP;
      min_code <= 2'd0;
      x0       <= '0;
      y0       <= '0;
      w        <= '0;
      h        <= '0;
      thr      <= '0;
    end else if (we) begin
      case (waddr)
        RA_COND: begin
          min_code <= wdata[1:0];
          if (wdata[3:2] != DIR_RSVD) dir <= wdata[3:2];
        end
        RA_X0:     x0  <= X_W'(clamp_max(wd32, 32'(X_MAX)));
        RA_Y0:     y0  <= Y_W'(clamp_max(wd32, 32'(Y_MAX)));
        RA_THR:    thr <= T_W'(clamp_max(wd32, 32'(T_MAX)));
        RA_WIDTH:  w   <= wdata[W_W-1:0];
        RA_HEIGHT: h   <= wdata[H_W-1:0];
        default: ;
      endcase
    end
  end

  // Aligned base registers: one per slot, low ALIGN bits tied to zero
  for (genvar gi = 0; gi < NBASE; gi++) begin : g_base
    localparam logic [3:0] SLOT_ADDR = (gi == 0) ? RA_PIC : RA_WORK;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        base_q[gi] <= '0;
      else if (we && waddr == SLOT_ADDR)
        base_q[gi] <= {wdata[DW-1:ALIGN], {ALIGN{1'b0}}};
    end
  end

  assign pic_base  = base_q[0];
  assign work_base = base_q[1];

endmodule

// File: rtl/det_job_seq.sv
module det_job_seq
  import djs_pkg::*;
#(
  parameter int DW      = 32,
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 35,
  parameter int X_W     = 8,
  parameter int Y_W     = 7,
  parameter int W_W     = 9,
  parameter int H_W     = 8,
  parameter int T_W     = 4,
  parameter int X_MAX   = 160,
  parameter int Y_MAX   = 120,
  parameter int T_MAX   = 9,
  parameter int ALIGN   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [3:0]       wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [3:0]       rd_addr,
  output logic [DW-1:0]    rd_data,
  input  logic             eng_done,
  input  logic [CNT_W-1:0] eng_count,
  input  logic             eng_bus_err,
  output logic             eng_start,
  output logic             eng_sreset,
  output logic             evt_done,
  output logic             evt_err,
  output logic [1:0]       cond_dir,
  output logic [5:0]       cond_min_px,
  output logic [X_W-1:0]   area_x0,
  output logic [Y_W-1:0]   area_y0,
  output logic [W_W-1:0]   area_w,
  output logic [H_W-1:0]   area_h,
  output logic [T_W-1:0]   hit_thr,
  output logic [DW-1:0]    pic_base,
  output logic [DW-1:0]    work_base
);

  // Named internal events, visible to the bound checker
  logic             ctrl_we;
  logic             ctrl_acc;
  logic             start_ok;
  logic             done_ok;
  logic             job_busy;
  logic             job_fin;
  logic [CNT_W-1:0] job_count;
  logic [1:0]       min_code;
  logic             err_q;

  assign ctrl_we = wr_en && (wr_addr == RA_CTRL);

  djs_ctrl #(.CNT_W(CNT_W), .CNT_MAX(CNT_MAX)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_we    (ctrl_we),
    .ctrl_wdata (wr_data[2:0]),
    .eng_done   (eng_done),
    .eng_count  (eng_count),
    .busy       (job_busy),
    .fin        (job_fin),
    .sreset     (eng_sreset),
    .start_pulse(eng_start),
    .done_evt   (evt_done),
    .count      (job_count),
    .ctrl_acc   (ctrl_acc),
    .start_ok   (start_ok),
    .done_ok    (done_ok)
  );

  djs_params #(
    .DW(DW), .X_W(X_W), .Y_W(Y_W), .W_W(W_W), .H_W(H_W), .T_W(T_W),
    .X_MAX(X_MAX), .Y_MAX(Y_MAX), .T_MAX(T_MAX), .ALIGN(ALIGN)
  ) u_params (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (wr_en),
    .waddr    (wr_addr),
    .wdata    (wr_data),
    .dir      (cond_dir),
    .min_code (min_code),
    .x0       (area_x0),
    .y0       (area_y0),
    .w        (area_w),
    .h        (area_h),
    .thr      (hit_thr),
    .pic_base (pic_base),
    .work_base(work_base)
  );

  assign cond_min_px = min_code_px(min_code);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= eng_bus_err;
  end
  assign evt_err = err_q;

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      RA_CTRL:   rd_data = DW'({job_fin, job_busy, eng_sreset});
      RA_COUNT:  rd_data = DW'(job_count);
      RA_COND:   rd_data = DW'({cond_dir, min_code});
      RA_X0:     rd_data = DW'(area_x0);
      RA_Y0:     rd_data = DW'(area_y0);
      RA_WIDTH:  rd_data = DW'(area_w);
      RA_HEIGHT: rd_data = DW'(area_h);
      RA_THR:    rd_data = DW'(hit_thr);
      RA_PIC:    rd_data = pic_base;
      RA_WORK:   rd_data = work_base;
      default:   rd_data = '0;
    endcase
  end

endmodule

// File: rtl/djs_chk.sv
module djs_chk #(
  parameter int DW      = 32,
  parameter int CNT_W   = 6,
  parameter int CNT_MAX = 35,
  parameter int X_W     = 8,
  parameter int Y_W     = 7,
  parameter int T_W     = 4,
  parameter int X_MAX   = 160,
  parameter int Y_MAX   = 120,
  parameter int T_MAX   = 9,
  parameter int ALIGN   = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [3:0]       wr_addr,
  input logic [DW-1:0]    wr_data,
  input logic             eng_bus_err,
  input logic             eng_start,
  input logic             eng_sreset,
  input logic             evt_done,
  input logic             evt_err,
  input logic             start_ok,
  input logic             job_busy,
  input logic             job_fin,
  input logic [CNT_W-1:0] job_count,
  input logic [1:0]       cond_dir,
  input logic [X_W-1:0]   area_x0,
  input logic [Y_W-1:0]   area_y0,
  input logic [T_W-1:0]   hit_thr,
  input logic [DW-1:0]    pic_base,
  input logic [DW-1:0]    work_base
);

  localparam logic [CNT_W-1:0] CAP  = CNT_W'(CNT_MAX);
  localparam logic [X_W-1:0]   XLIM = X_W'(X_MAX);
  localparam logic [Y_W-1:0]   YLIM = Y_W'(Y_MAX);
  localparam logic [T_W-1:0]   TLIM = T_W'(T_MAX);

  a_r2_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |=> !eng_start);

  a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> job_busy);

  a_r3_start_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
    start_ok |-> (!job_busy && !eng_sreset));

  a_r4_done_state: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> (job_fin && !job_busy));

  a_r4_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    evt_done |-> $past(job_busy));

  a_r5_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    job_count <= CAP);

  a_r7_reset_idle: assert property (@(posedge clk) disable iff (!rst_n)
    eng_sreset |-> !job_busy);

  a_r8_all_bits_no_start: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 4'd0 && (&wr_data[2:0])) |=> !eng_start);

  a_r9_clamped: assert property (@(posedge clk) disable iff (!rst_n)
    (area_x0 <= XLIM) && (area_y0 <= YLIM) && (hit_thr <= TLIM));

  a_r10_dir_legal: assert property (@(posedge clk) disable iff (!rst_n)
    cond_dir != 2'd3);

  a_r11_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (pic_base[ALIGN-1:0] == '0) && (work_base[ALIGN-1:0] == '0));

  a_r12_err_follows: assert property (@(posedge clk) disable iff (!rst_n)
    evt_err |-> $past(eng_bus_err));

endmodule

bind det_job_seq djs_chk #(
  .DW(DW), .CNT_W(CNT_W), .CNT_MAX(CNT_MAX), .X_W(X_W), .Y_W(Y_W), .T_W(T_W),
  .X_MAX(X_MAX), .Y_MAX(Y_MAX), .T_MAX(T_MAX), .ALIGN(ALIGN)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .eng_bus_err(eng_bus_err),
  .eng_start  (eng_start),
  .eng_sreset (eng_sreset),
  .evt_done   (evt_done),
  .evt_err    (evt_err),
  .start_ok   (start_ok),
  .job_busy   (job_busy),
  .job_fin    (job_fin),
  .job_count  (job_count),
  .cond_dir   (cond_dir),
  .area_x0    (area_x0),
  .area_y0    (area_y0),
  .hit_thr    (hit_thr),
  .pic_base   (pic_base),
  .work_base  (work_base)
);

// File: tb/sim_det_job_seq.sv
module sim_det_job_seq;

  localparam int K_START = 0;
  localparam int K_DONE  = 1;
  localparam int K_ERR   = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        eng_done = 1'b0;
  logic [5:0]  eng_count = '0;
  logic        eng_bus_err = 1'b0;
  logic        eng_start, eng_sreset, evt_done, evt_err;
  logic [1:0]  cond_dir;
  logic [5:0]  cond_min_px;
  logic [7:0]  area_x0;
  logic [6:0]  area_y0;
  logic [8:0]  area_w;
  logic [7:0]  area_h;
  logic [3:0]  hit_thr;
  logic [31:0] pic_base, work_base;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  int q_kind[$];
  int q_cyc[$];
  bit done_flag = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  det_job_seq u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .eng_done(eng_done), .eng_count(eng_count),
    .eng_bus_err(eng_bus_err), .eng_start(eng_start), .eng_sreset(eng_sreset),
    .evt_done(evt_done), .evt_err(evt_err), .cond_dir(cond_dir),
    .cond_min_px(cond_min_px), .area_x0(area_x0), .area_y0(area_y0),
    .area_w(area_w), .area_h(area_h), .hit_thr(hit_thr),
    .pic_base(pic_base), .work_base(work_base)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Scoreboard monitor: every observed pulse must match the queue front
  task automatic match_pulse(input int kind);
    checks++;
    if (q_kind.size() == 0 || q_kind[0] != kind || q_cyc[0] != cyc) begin
      fails++;
      $display("FAIL R2/R3/R4/R8/R12 pulse kind=%0d at cycle %0d expected kind=%0d cycle=%0d",
               kind, cyc, (q_kind.size() != 0) ? q_kind[0] : -1,
               (q_cyc.size() != 0) ? q_cyc[0] : -1);
    end else begin
      void'(q_kind.pop_front());
      void'(q_cyc.pop_front());
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (eng_start) match_pulse(K_START);
      if (evt_done)  match_pulse(K_DONE);
      if (evt_err)   match_pulse(K_ERR);
    end
  end

  task automatic push(input int kind);
    q_kind.push_back(kind);
    q_cyc.push_back(cyc + 1);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d, input bit exp_start);
    @(negedge clk);
    if (exp_start) push(K_START);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic done_pulse(input logic [5:0] n, input bit exp_evt);
    @(negedge clk);
    if (exp_evt) push(K_DONE);
    eng_done = 1'b1; eng_count = n;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    rd_addr = a;
    #1;
    check(tag, rd_data, exp);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R13 reset state
    rd(4'd0, 32'h0, "R13 ctrl after reset");
    rd(4'd1, 32'h0, "R13 count after reset");
    check("R13 min px after reset", 32'(cond_min_px), 32'd20);
    check("R13 sreset after reset", 32'(eng_sreset), 32'd0);

    // R1 R2: start from idle
    wr(4'd0, 32'h2, 1);
    rd(4'd0, 32'h2, "R1 R2 running bit after start");
    // R3: start while busy ignored
    wr(4'd0, 32'h2, 0);
    rd(4'd0, 32'h2, "R3 restart while busy");
    // R4 R5: done
    done_pulse(6'd5, 1);
    rd(4'd0, 32'h4, "R4 complete after done");
    rd(4'd1, 32'd5, "R5 count captured");
    // R6
    wr(4'd0, 32'h0, 0);
    rd(4'd0, 32'h4, "R6 write zero keeps complete");
    wr(4'd0, 32'h4, 0);
    rd(4'd0, 32'h0, "R6 clear complete");
    // R4 idle done ignored
    done_pulse(6'd9, 0);
    rd(4'd0, 32'h0, "R4 idle done no status");
    rd(4'd1, 32'd5, "R4 idle done no count");
    // R5 saturation
    wr(4'd0, 32'h2, 1);
    done_pulse(6'd50, 1);
    rd(4'd1, 32'd35, "R5 count saturates");
    wr(4'd0, 32'h4, 0);

    // R7 engine reset level, R3 start with reset
    wr(4'd0, 32'h1, 0);
    rd(4'd0, 32'h1, "R7 reset reads back");
    check("R7 sreset output high", 32'(eng_sreset), 32'd1);
    wr(4'd0, 32'h3, 0);
    rd(4'd0, 32'h1, "R3 start during reset ignored");
    wr(4'd0, 32'h0, 0);
    check("R7 sreset released", 32'(eng_sreset), 32'd0);
    // R7 abort
    wr(4'd0, 32'h2, 1);
    wr(4'd0, 32'h1, 0);
    rd(4'd0, 32'h1, "R7 reset aborts job");
    done_pulse(6'd3, 0);
    rd(4'd0, 32'h1, "R7 done after abort ignored");
    wr(4'd0, 32'h0, 0);

    // R8 all three bits dropped, idle and busy
    wr(4'd0, 32'h7, 0);
    rd(4'd0, 32'h0, "R8 all bits idle");
    wr(4'd0, 32'h2, 1);
    wr(4'd0, 32'h7, 0);
    rd(4'd0, 32'h2, "R8 all bits while running");
    check("R8 no engine reset", 32'(eng_sreset), 32'd0);
    done_pulse(6'd35, 1);
    rd(4'd1, 32'd35, "R5 count at cap");
    wr(4'd0, 32'h4, 0);

    // R9 clamps
    wr(4'd3, 32'd200, 0);
    rd(4'd3, 32'd160, "R9 x clamp");
    wr(4'd3, 32'd100, 0);
    check("R9 x in range", 32'(area_x0), 32'd100);
    wr(4'd4, 32'd127, 0);
    rd(4'd4, 32'd120, "R9 y clamp");
    wr(4'd7, 32'd15, 0);
    check("R9 thr clamp", 32'(hit_thr), 32'd9);
    wr(4'd7, 32'd9, 0);
    rd(4'd7, 32'd9, "R9 thr at limit");
    wr(4'd5, 32'd300, 0);
    wr(4'd6, 32'd200, 0);
    check("R9 width stored", 32'(area_w), 32'd300);
    rd(4'd6, 32'd200, "R9 height stored");

    // R10 condition
    wr(4'd2, 32'h6, 0);
    rd(4'd2, 32'h6, "R10 dir right min code 2");
    check("R10 min px 32", 32'(cond_min_px), 32'd32);
    wr(4'd2, 32'hF, 0);
    check("R10 reserved dir kept", 32'(cond_dir), 32'd1);
    check("R10 min px 40", 32'(cond_min_px), 32'd40);

    // R11 bases
    wr(4'd8, 32'hFFFF_FFFF, 0);
    rd(4'd8, 32'hFFFF_FFE0, "R11 picture base");
    wr(4'd9, 32'h1234_567F, 0);
    check("R11 work base", work_base, 32'h1234_5660);

    // R12 bus error
    @(negedge clk);
    push(K_ERR);
    eng_bus_err = 1'b1;
    @(negedge clk);
    eng_bus_err = 1'b0;
    repeat (3) @(negedge clk);

    check("R2 R4 R12 all expected pulses seen", 32'(q_kind.size()), 32'd0);
    done_flag = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule